// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side storage and status stage of a UART. A separate shifter samples the line and hands over each finished character together with its error flags, and it also raises a strobe when it sees a valid start bit. The buffer puts characters into a FIFO that the host drains one at a time. It builds up a status word in which each error bit is the OR of every character received since the host last cleared the status.

When the FIFO is full, one more character waits in a single holding stage. It drops into the FIFO as soon as the host frees a slot. If yet another character completes while that stage is still occupied, the waiting character is replaced and the FIFO is left untouched. The overrun flag is raised earlier than that: it sets as soon as the start bit of the overrunning character is seen.

An optional automatic flow-control mode drives an active-low request-to-send output. The output is negated when a start bit arrives while the FIFO is full, and it is asserted again once a slot is free. A synchronous receiver reset empties everything. Disabling the receiver stops intake but leaves reads working.

Top module: `uart_rx_buffer`

## Requirements
- R1: After the asynchronous reset, `buf_valid`, `buf_full`, `err_flags` and `ovr_flag` are all 0, and `rts_n` is 0, meaning asserted.
- R2: Characters leave in arrival order, and the head is shown on `buf_data` while `buf_valid` is 1. Only a `rd_buf` pulse removes a character. A `rd_buf` pulse on an empty buffer is ignored.
- R3: A `rd_stat` pulse leaves the FIFO unchanged. On the next cycle it loads `stat_word` with a snapshot laid out as follows: bit 0 is valid, bit 1 is full, bits ERR_W+1..2 are the error flags, and bit ERR_W+2 is overrun.
- R4: `err_flags` is the bitwise OR of `char_err` over all characters accepted since the last `clr_err`. When a clear and a new character fall in the same cycle, the new character's flags remain set.
- R5: A character that completes while the FIFO is full goes into the holding stage. It is written into the FIFO in the same cycle that a pop frees a slot, so the buffer stays full.
- R6: A character that completes while the holding stage is occupied and no slot frees in that cycle replaces the held character. The discarded character never appears, and the FIFO contents are unchanged.
- R7: `ovr_flag` sets on the cycle after `start_det` is seen while the holding stage is occupied, the FIFO is full and no pop occurs. It stays set until `clr_err` or a receiver reset.
- R8: With `auto_rts_en` set, a start bit seen while the FIFO is full drives `rts_n` to 1 on the next cycle. Once the FIFO is no longer full, `rts_n` returns to 0 one cycle later.
- R9: With `auto_rts_en` clear, `rts_n` stays 0.
- R10: While `rx_en` is 0, `char_done` and `start_det` have no effect, and buffered characters can still be read.
- R11: A `rx_reset` pulse empties the FIFO and the holding stage, clears the error and overrun flags and the snapshot, and asserts `rts_n`, all on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | Shifter saw a valid start bit (one-cycle strobe) |
| char_done | input | 1 | Shifter finished a character (one-cycle strobe) |
| char_data | input | DATA_W | Finished character |
| char_err | input | ERR_W | Error flags of the finished character |
| rx_en | input | 1 | Receiver enable |
| rx_reset | input | 1 | Synchronous receiver reset command |
| auto_rts_en | input | 1 | Enables automatic request-to-send control |
| rd_buf | input | 1 | Host reads and pops the buffer head |
| rd_stat | input | 1 | Host reads the status word |
| clr_err | input | 1 | Clears the accumulated error and overrun flags |
| buf_data | output | DATA_W | Buffer head character |
| buf_valid | output | 1 | Buffer holds at least one character |
| buf_full | output | 1 | All FIFO slots occupied |
| err_flags | output | ERR_W | Accumulated error flags |
| ovr_flag | output | 1 | Sticky overrun flag |
| stat_word | output | ERR_W+3 | Status snapshot taken on `rd_stat` |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Several properties are checked on every cycle by the assertions:
- the error and overrun flags never drop without a clear or a reset;
- the buffer head is never lost without a pop;
- a full FIFO is never written unless a slot frees in the same cycle;
- the receiver reset lands in a clean state;
- request-to-send reacts correctly to a start bit on a full FIFO, and stays low when automatic control is off.

Other behaviour can only be shown by the bench's scenarios:
- data order through the FIFO;
- the holding stage replacing a waiting character, so that exactly one of two late characters survives;
- the snapshot encoding;
- the delayed reassertion of request-to-send after two pops.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

  // Where an accepted character is steered in a given cycle
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_FIFO = 2'd1,
    ROUTE_HOLD = 2'd2
  } route_e;

endpackage

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CMAX);
  assign head    = mem_q[rd_q];
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; it is written only under its enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && !clear && (wr_q == AW'(i))) mem_q[i] <= push_data;
    end
  end

endmodule

// File: rtl/uart_rxb_hold.sv
module uart_rxb_hold
  import uart_rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [DATA_W-1:0] char_data,
  input  logic              fifo_full,
  input  logic              pop_eff,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              hold_v
);
  logic              hv_q, hv_d;
  logic [DATA_W-1:0] hd_q, hd_d;
  logic              room;
  route_e            route;

  assign room   = !fifo_full || pop_eff;
  assign hold_v = hv_q;

  always_comb begin
    route = ROUTE_NONE;
    if (accept) route = (hv_q || !room) ? ROUTE_HOLD : ROUTE_FIFO;
  end

  always_comb begin
    push      = 1'b0;
    push_data = char_data;
    hv_d      = hv_q;
    hd_d      = hd_q;
    if (hv_q) begin
      // Held character has priority for the free slot
      push      = room;
      push_data = hd_q;
      if (room) hv_d = 1'b0;
    end else if (route == ROUTE_FIFO) begin
      push = 1'b1;
    end
    if (route == ROUTE_HOLD) begin
      // Overwrites a held character that could not drain
      hv_d = 1'b1;
      hd_d = char_data;
    end
    if (clear) hv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= 1'b0;
    else        hv_q <= hv_d;
  end

  always_ff @(posedge clk) begin
    if (route == ROUTE_HOLD) hd_q <= hd_d;
  end

endmodule

// File: rtl/uart_rxb_status.sv
module uart_rxb_status #(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic [ERR_W-1:0] char_err,
  input  logic             ovr_set,
  input  logic             clr_err,
  input  logic             rd_stat,
  input  logic             buf_valid,
  input  logic             buf_full,
  output logic [ERR_W-1:0] err_flags,
  output logic             ovr_flag,
  output logic [ERR_W+2:0] stat_word
);
  logic [ERR_W-1:0] err_q, err_d;
  logic             ovr_q, ovr_d;
  logic [ERR_W+2:0] snap_q, snap_d;

  always_comb begin
    err_d  = (clr_err ? '0 : err_q) | (accept ? char_err : '0);
    ovr_d  = (clr_err ? 1'b0 : ovr_q) | ovr_set;
    snap_d = rd_stat ? {ovr_q, err_q, buf_full, buf_valid} : snap_q;
    if (clear) begin
      err_d  = '0;
      ovr_d  = 1'b0;
      snap_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      ovr_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      err_q  <= err_d;
      ovr_q  <= ovr_d;
      snap_q <= snap_d;
    end
  end

  assign err_flags = err_q;
  assign ovr_flag  = ovr_q;
  assign stat_word = snap_q;

endmodule

// File: rtl/uart_rxb_rts.sv
module uart_rxb_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic auto_en,
  input  logic start_acc,
  input  logic fifo_full,
  output logic rts_n
);
  logic neg_q, neg_d;

  always_comb begin
    neg_d = neg_q;
    if (clear || !auto_en)          neg_d = 1'b0;
    else if (start_acc && fifo_full) neg_d = 1'b1;
    else if (!fifo_full)             neg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= neg_d;
  end

  assign rts_n = neg_q;

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic [ERR_W-1:0]  char_err,
  input  logic              rx_en,
  input  logic              rx_reset,
  input  logic              auto_rts_en,
  input  logic              rd_buf,
  input  logic              rd_stat,
  input  logic              clr_err,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_valid,
  output logic              buf_full,
  output logic [ERR_W-1:0]  err_flags,
  output logic              ovr_flag,
  output logic [ERR_W+2:0]  stat_word,
  output logic              rts_n
);
  logic              accept, start_acc, pop_eff, ovr_set;
  logic              fifo_push, fifo_empty, hold_v;
  logic [DATA_W-1:0] fifo_wdata;

  assign accept    = char_done && rx_en;
  assign start_acc = start_det && rx_en;
  assign pop_eff   = rd_buf && !fifo_empty;
  assign ovr_set   = start_acc && hold_v && buf_full && !pop_eff;
  assign buf_valid = !fifo_empty;

  uart_rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(rx_reset),
    .push(fifo_push), .push_data(fifo_wdata), .pop(rd_buf),
    .head(buf_data), .empty(fifo_empty), .full(buf_full)
  );

  uart_rxb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(rx_reset),
    .accept(accept), .char_data(char_data),
    .fifo_full(buf_full), .pop_eff(pop_eff),
    .push(fifo_push), .push_data(fifo_wdata), .hold_v(hold_v)
  );

  uart_rxb_status #(.ERR_W(ERR_W)) u_status (
    .clk(clk), .rst_n(rst_n), .clear(rx_reset),
    .accept(accept), .char_err(char_err), .ovr_set(ovr_set),
    .clr_err(clr_err), .rd_stat(rd_stat),
    .buf_valid(buf_valid), .buf_full(buf_full),
    .err_flags(err_flags), .ovr_flag(ovr_flag), .stat_word(stat_word)
  );

  uart_rxb_rts u_rts (
    .clk(clk), .rst_n(rst_n), .clear(rx_reset),
    .auto_en(auto_rts_en), .start_acc(start_acc),
    .fifo_full(buf_full), .rts_n(rts_n)
  );

endmodule

// File: rtl/uart_rx_buffer_sva.sv
module uart_rx_buffer_sva #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             rx_en,
  input logic             rx_reset,
  input logic             auto_rts_en,
  input logic             rd_buf,
  input logic             clr_err,
  input logic             buf_valid,
  input logic             buf_full,
  input logic [ERR_W-1:0] err_flags,
  input logic             ovr_flag,
  input logic             rts_n,
  input logic             fifo_push
);

  // R4: accumulated errors only grow between clears
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_err && !rx_reset) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R7: overrun flag holds until a clear
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_err && !rx_reset) |=> ovr_flag);

  // R2, R3: the head is never lost without a pop
  a_r2_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !rd_buf && !rx_reset) |=> buf_valid);

  // R5: a full FIFO is written only when a slot frees in that cycle
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && buf_full) |-> rd_buf);

  // R8: a start bit on a full FIFO negates request-to-send
  a_r8_rts_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_en && start_det && buf_full && !rx_reset) |=> rts_n);

  // R9: manual mode keeps request-to-send asserted
  a_r9_rts_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rts_en) |=> !rts_n);

  // R11: receiver reset lands in a clean state
  a_r11_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!buf_valid && !buf_full && (err_flags == '0) && !ovr_flag && !rts_n));

endmodule

bind uart_rx_buffer uart_rx_buffer_sva #(.ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .rx_en(rx_en),
  .rx_reset(rx_reset), .auto_rts_en(auto_rts_en), .rd_buf(rd_buf),
  .clr_err(clr_err), .buf_valid(buf_valid), .buf_full(buf_full),
  .err_flags(err_flags), .ovr_flag(ovr_flag), .rts_n(rts_n),
  .fifo_push(fifo_push)
);

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;
  localparam int DW = 8;
  localparam int EW = 3;
  localparam int DP = 8;

  logic clk, rst_n;
  logic start_det, char_done, rx_en, rx_reset, auto_rts_en;
  logic rd_buf, rd_stat, clr_err;
  logic [DW-1:0] char_data, buf_data;
  logic [EW-1:0] char_err, err_flags;
  logic buf_valid, buf_full, ovr_flag, rts_n;
  logic [EW+2:0] stat_word;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q [$];

  uart_rx_buffer #(.DATA_W(DW), .ERR_W(EW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .char_done(char_done),
    .char_data(char_data), .char_err(char_err), .rx_en(rx_en),
    .rx_reset(rx_reset), .auto_rts_en(auto_rts_en), .rd_buf(rd_buf),
    .rd_stat(rd_stat), .clr_err(clr_err), .buf_data(buf_data),
    .buf_valid(buf_valid), .buf_full(buf_full), .err_flags(err_flags),
    .ovr_flag(ovr_flag), .stat_word(stat_word), .rts_n(rts_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: one character strobe; the scoreboard entry is pushed by the caller
  task automatic send(input logic [DW-1:0] d, input logic [EW-1:0] e);
    @(negedge clk);
    char_done = 1'b1; char_data = d; char_err = e;
    @(negedge clk);
    char_done = 1'b0; char_err = '0;
  endtask

  task automatic start_bit();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  // Monitor: compare the head with the scoreboard, then pop
  task automatic read_chk(input string req);
    logic [DW-1:0] e;
    e = exp_q.pop_front();
    check(req, {24'h0, buf_data}, {24'h0, e});
    @(negedge clk); rd_buf = 1'b1;
    @(negedge clk); rd_buf = 1'b0;
  endtask

  task automatic pulse_reset_cmd();
    @(negedge clk); rx_reset = 1'b1;
    @(negedge clk); rx_reset = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_det = 0; char_done = 0; char_data = '0; char_err = '0;
    rx_en = 1; rx_reset = 0; auto_rts_en = 0;
    rd_buf = 0; rd_stat = 0; clr_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", buf_valid, 0);
    check("R1 full", buf_full, 0);
    check("R1 err", err_flags, 0);
    check("R1 ovr", ovr_flag, 0);
    check("R1 rts", rts_n, 0);

    // R4 OR accumulation, R2 order
    send(8'hA1, 3'b001); exp_q.push_back(8'hA1);
    send(8'hA2, 3'b000); exp_q.push_back(8'hA2);
    send(8'hA3, 3'b100); exp_q.push_back(8'hA3);
    check("R4 accumulate", err_flags, 3'b101);
    read_chk("R2 order");
    read_chk("R2 order");
    read_chk("R2 order");
    check("R2 empty", buf_valid, 0);
    @(negedge clk); rd_buf = 1'b1;
    @(negedge clk); rd_buf = 1'b0;
    check("R2 pop on empty", buf_valid, 0);

    // R4 clear with a simultaneous character
    @(negedge clk);
    clr_err = 1; char_done = 1; char_data = 8'hB1; char_err = 3'b010;
    @(negedge clk);
    clr_err = 0; char_done = 0; char_err = '0;
    exp_q.push_back(8'hB1);
    check("R4 clear keeps new", err_flags, 3'b010);
    send(8'hB2, 3'b000); exp_q.push_back(8'hB2);

    // R3 status snapshot leaves the FIFO alone
    @(negedge clk); rd_stat = 1;
    @(negedge clk); rd_stat = 0;
    check("R3 snapshot", stat_word, 6'b001001);
    check("R3 head kept", buf_data, 8'hB1);
    read_chk("R3 after status");
    read_chk("R3 after status");
    check("R3 drained", buf_valid, 0);
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;

    // Fill, hold, overrun, replace, RTS
    auto_rts_en = 1;
    for (int i = 0; i < DP; i++) begin
      send(8'h10 + 8'(i), 3'b000);
      exp_q.push_back(8'h10 + 8'(i));
    end
    check("R5 full", buf_full, 1);
    start_bit();
    check("R8 negate", rts_n, 1);
    send(8'h71, 3'b000);
    check("R5 held keeps full", buf_full, 1);
    check("R7 no ovr yet", ovr_flag, 0);
    start_bit();
    check("R7 ovr at start", ovr_flag, 1);
    send(8'h72, 3'b000);
    read_chk("R5 first out");
    exp_q.push_back(8'h72);
    check("R5 hold drained full", buf_full, 1);
    check("R8 still negated", rts_n, 1);
    read_chk("R5 second out");
    check("R8 not full", buf_full, 0);
    @(negedge clk);
    check("R8 reassert", rts_n, 0);
    check("R7 sticky", ovr_flag, 1);
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
    check("R7 cleared", ovr_flag, 0);
    while (exp_q.size() > 0) read_chk("R6 survivor order");
    check("R6 drained", buf_valid, 0);

    // R10 disabled receiver
    send(8'h44, 3'b000); exp_q.push_back(8'h44);
    rx_en = 0;
    send(8'h55, 3'b111);
    start_bit();
    check("R10 err untouched", err_flags, 0);
    read_chk("R10 read while off");
    check("R10 no intake", buf_valid, 0);
    rx_en = 1;

    // R9 manual mode
    auto_rts_en = 0;
    for (int i = 0; i < DP; i++) begin
      send(8'h20 + 8'(i), 3'b000);
      exp_q.push_back(8'h20 + 8'(i));
    end
    start_bit();
    check("R9 rts low", rts_n, 0);

    // R11 receiver reset
    auto_rts_en = 1;
    start_bit();
    send(8'h99, 3'b011);
    start_bit();
    check("R11 pre ovr", ovr_flag, 1);
    pulse_reset_cmd();
    exp_q.delete();
    check("R11 valid", buf_valid, 0);
    check("R11 full", buf_full, 0);
    check("R11 err", err_flags, 0);
    check("R11 ovr", ovr_flag, 0);
    check("R11 rts", rts_n, 0);
    check("R11 snapshot", stat_word, 0);
    send(8'h66, 3'b000); exp_q.push_back(8'h66);
    @(negedge clk);
    check("R11 hold cleared", buf_valid, 1);
    read_chk("R11 fresh data");
    check("R11 single", buf_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule